// File: doc/BRIEF.md
# Delayed Data-Phase Parity Checker

This block sits on the receiving side of a wide data bus that moves a 32-byte block (four 64-bit qwords) in each bus clock. When the data-ready flag confirms a block, the block's expected 4-bit parity is computed and held for one clock. The four parity bits, which arrive one bus clock after their data, are then compared with that stored value. Each parity bit gives even parity over a diagonal set of 16-bit groups: the group index moves up by one for each qword.

A mismatch raises a one-cycle error pulse. It also sets a sticky hard-error flag and a sticky mask of the bits that disagreed, and both hold until a clear pulse arrives. A single enable bit turns checking on or off. Short transfers need no special handling: every qword slot on the bus counts toward the expected parity, whether or not it carried payload. Because the expected value is staged one clock, blocks can arrive on every clock.

Top module: `parity_chk`

## Requirements
- R1: Expected parity bit k is the XOR of 16-bit group (k+q) mod 4 of qword q, taken over q = 0..3. Qword q is at block bits [64q+63:64q], and group g of a qword is at bits [16g+15:16g] within it. Parity bits are active-high, and bit k on `par_i` is compared with expected bit k.
- R2: A block presented with `blk_rdy_i` high at clock edge E has its parity taken from `par_i` at edge E+1 and compared there. `par_i` is ignored at every edge that does not follow a ready edge.
- R3: When a comparison at edge E+1 finds any bit different and checking is enabled, `err_pulse_o` is high for exactly the clock after E+1. When all bits match, it stays low.
- R4: If `chk_en_i` is low at the comparison edge, no pulse is raised and the sticky state is not changed.
- R5: A detected mismatch sets `hard_err_o`, which stays high until a clear pulse.
- R6: `err_mask_o` accumulates, as a sticky OR, the bit positions that mismatched, until a clear pulse.
- R7: `sts_clr_i` high at an edge zeroes `hard_err_o` and `err_mask_o`. A mismatch detected at the same edge is still recorded, with only its own bits.
- R8: All four qword slots count toward the expected parity, including slots that carry no payload in a short transfer.
- R9: Blocks on consecutive ready edges are each checked against the parity that follows them.
- R10: While `rst_n` is low, every output is zero and no comparison is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en_i | input | 1 | Checking enable |
| blk_rdy_i | input | 1 | Confirms the block on `blk_data_i` |
| blk_data_i | input | 256 | Four qwords, qword 0 in the low bits |
| par_i | input | 4 | Parity bits for the previous block |
| sts_clr_i | input | 1 | Clears the sticky status |
| err_pulse_o | output | 1 | One-cycle mismatch pulse |
| hard_err_o | output | 1 | Sticky hard-error flag |
| err_mask_o | output | 4 | Sticky mismatching-bit mask |

## Verification
A wrong stored expected value, or a pending flag that is missing or left over, shows at the ports one clock after the parity edge. The symptom is either a false `err_pulse_o` or a missing one, and in either case the sticky mask then disagrees from that clock until the next clear. Sticky-state faults, such as a flag that drops on its own or a clear that loses a simultaneous error, show up in the status outputs in the clock right after the edge in question. The reference model is compared with the outputs on every clock, so any of these faults is reported within one cycle of the edge that caused it.

// File: rtl/parity_chk.sv
module parity_chk #(
  parameter int QW_W = 64,
  parameter int NQ   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_en_i,
  input  logic                 blk_rdy_i,
  input  logic [QW_W*NQ-1:0]   blk_data_i,
  input  logic [NQ-1:0]        par_i,
  input  logic                 sts_clr_i,
  output logic                 err_pulse_o,
  output logic                 hard_err_o,
  output logic [NQ-1:0]        err_mask_o
);
  localparam int GRP_W = QW_W / NQ;

  logic [NQ-1:0] exp_c, exp_q, diff;
  logic          pend_q;

  always_comb begin
    exp_c = '0;
    for (int k = 0; k < NQ; k++)
      for (int q = 0; q < NQ; q++)
        exp_c[k] = exp_c[k] ^ (^blk_data_i[q*QW_W + ((k+q)%NQ)*GRP_W +: GRP_W]);
  end

  assign diff = (pend_q && chk_en_i) ? (par_i ^ exp_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      exp_q       <= '0;
      err_pulse_o <= 1'b0;
      hard_err_o  <= 1'b0;
      err_mask_o  <= '0;
    end else begin
      pend_q      <= blk_rdy_i;
      if (blk_rdy_i) exp_q <= exp_c;
      err_pulse_o <= |diff;
      hard_err_o  <= (hard_err_o & ~sts_clr_i) | (|diff);
      err_mask_o  <= (sts_clr_i ? '0 : err_mask_o) | diff;
    end
  end
endmodule

// File: rtl/parity_chk_sva.sv
module parity_chk_sva #(
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chk_en_i,
  input logic          blk_rdy_i,
  input logic          sts_clr_i,
  input logic          err_pulse_o,
  input logic          hard_err_o,
  input logic [NQ-1:0] err_mask_o
);
  a_r2_err_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> $past(blk_rdy_i, 2));

  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chk_en_i) |-> !err_pulse_o);

  a_r5_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> hard_err_o);

  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hard_err_o) && !$past(sts_clr_i)) |-> hard_err_o);

  a_r6_mask_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> (err_mask_o != '0));

  a_r6_flag_mask_agree: assert property (@(posedge clk) disable iff (!rst_n)
    hard_err_o == (err_mask_o != '0));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_clr_i) && !err_pulse_o) |-> (!hard_err_o && err_mask_o == '0));
endmodule

bind parity_chk parity_chk_sva #(.NQ(NQ)) u_sva (
  .clk(clk), .rst_n(rst_n), .chk_en_i(chk_en_i), .blk_rdy_i(blk_rdy_i),
  .sts_clr_i(sts_clr_i), .err_pulse_o(err_pulse_o), .hard_err_o(hard_err_o),
  .err_mask_o(err_mask_o)
);

// File: tb/sim_parity_chk.sv
module sim_parity_chk;
  localparam int PER = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chk_en_i = 1'b0, blk_rdy_i = 1'b0, sts_clr_i = 1'b0;
  logic [255:0] blk_data_i = '0;
  logic [3:0]   par_i = '0;
  logic         err_pulse_o, hard_err_o;
  logic [3:0]   err_mask_o;

  int n_chk = 0, n_bad = 0;

  logic       m_pend = 1'b0, m_err = 1'b0, m_hard = 1'b0;
  logic [3:0] m_exp = '0, m_mask = '0;

  always #(PER/2) clk = ~clk;

  parity_chk u0 (.*);

  function automatic logic [3:0] ref_par(logic [255:0] d);
    logic [3:0] p = '0;
    for (int i = 0; i < 256; i++) begin
      int q = i / 64;
      int g = (i % 64) / 16;
      p[(g - q + 4) % 4] ^= d[i];
    end
    return p;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic rdy, logic [255:0] d, logic [3:0] p, logic en, logic clr);
    logic [3:0] df;
    blk_rdy_i = rdy; blk_data_i = d; par_i = p; chk_en_i = en; sts_clr_i = clr;
    @(posedge clk);
    df     = (m_pend && en) ? (p ^ m_exp) : 4'b0;
    m_err  = |df;
    m_hard = (m_hard && !clr) || m_err;
    m_mask = (clr ? 4'b0 : m_mask) | df;
    m_pend = rdy;
    if (rdy) m_exp = ref_par(d);
    @(negedge clk);
    chk("R3 pulse", {3'b0, err_pulse_o}, {3'b0, m_err});
    chk("R5 flag",  {3'b0, hard_err_o},  {3'b0, m_hard});
    chk("R6 mask",  err_mask_o, m_mask);
  endtask

  initial begin
    #(PER * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [255:0] a, b, s;
    repeat (3) @(negedge clk);
    chk("R10 reset pulse", {3'b0, err_pulse_o}, 4'h0);
    chk("R10 reset flag",  {3'b0, hard_err_o},  4'h0);
    chk("R10 reset mask",  err_mask_o, 4'h0);
    rst_n = 1'b1;

    a = rnd256();
    step(1, a, 4'h0, 1, 0);
    step(0, '0, ref_par(a), 1, 0);
    chk("R1 match no error", {3'b0, err_pulse_o}, 4'h0);

    a = 256'h1;
    step(1, a, 4'h0, 1, 0);
    step(0, '0, 4'b0001, 1, 0);
    chk("R1 bit0 group0 qword0", {3'b0, err_pulse_o}, 4'h0);
    a = 256'h1 << (64 + 16);
    step(1, a, 4'h0, 1, 0);
    step(0, '0, 4'b0001, 1, 0);
    chk("R1 qword1 group1 maps to bit0", {3'b0, err_pulse_o}, 4'h0);

    b = rnd256();
    step(1, b, 4'h0, 1, 0);
    step(0, '0, ref_par(b) ^ 4'b0100, 1, 0);
    chk("R3 mismatch pulse", {3'b0, err_pulse_o}, 4'h1);
    chk("R6 mismatch mask", err_mask_o, 4'b0100);
    step(0, '0, 4'h0, 1, 0);
    chk("R3 single cycle", {3'b0, err_pulse_o}, 4'h0);
    chk("R5 flag held", {3'b0, hard_err_o}, 4'h1);

    step(0, '0, 4'h0, 1, 1);
    chk("R7 clear flag", {3'b0, hard_err_o}, 4'h0);
    chk("R7 clear mask", err_mask_o, 4'h0);

    step(0, '0, 4'hF, 1, 0);
    chk("R2 parity ignored off-slot", {3'b0, err_pulse_o}, 4'h0);

    a = rnd256(); b = rnd256();
    step(1, a, 4'h3, 1, 0);
    step(1, b, ref_par(a), 1, 0);
    chk("R9 first block ok", {3'b0, err_pulse_o}, 4'h0);
    step(0, '0, ref_par(b) ^ 4'b0001, 1, 0);
    chk("R9 second block err", err_mask_o, 4'b0001);

    a = rnd256();
    step(1, a, 4'h0, 1, 0);
    step(0, '0, ref_par(a) ^ 4'b1000, 1, 1);
    chk("R7 same-edge error kept", {3'b0, hard_err_o}, 4'h1);
    chk("R7 same-edge mask", err_mask_o, 4'b1000);
    step(0, '0, 4'h0, 1, 1);

    a = rnd256();
    step(1, a, 4'h0, 1, 0);
    step(0, '0, ref_par(a) ^ 4'hF, 0, 0);
    chk("R4 disabled no pulse", {3'b0, err_pulse_o}, 4'h0);
    chk("R4 disabled no flag", {3'b0, hard_err_o}, 4'h0);
    chk("R4 disabled no mask", err_mask_o, 4'h0);

    s = rnd256();
    s[255:128] = {64'h0, 64'h0000_0000_0001_0000};
    step(1, s, 4'h0, 1, 0);
    step(0, '0, ref_par(s), 1, 0);
    chk("R8 all slots counted ok", {3'b0, err_pulse_o}, 4'h0);
    step(1, s, 4'h0, 1, 0);
    step(0, '0, ref_par({128'b0, s[127:0]}), 1, 0);
    chk("R8 leading-only parity rejected", err_mask_o, 4'b1000);
    step(0, '0, 4'h0, 1, 1);

    for (int i = 0; i < 200; i++) begin
      logic [255:0] d = rnd256();
      logic [3:0]   p = (($urandom % 3) == 0) ? 4'($urandom) : m_exp;
      step(1'($urandom), d, p, ($urandom % 5) != 0, ($urandom % 7) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule